// File: doc/BRIEF.md
# Memory Request Coalescing Unit

This unit takes one group of up to 32 parallel read requests. Each lane may carry a byte address and an access width of 4, 8 or 16 bytes. The unit folds every request that lands in the same aligned memory segment into one wide transaction. It sends the fewest segment fetches the group needs, one per cycle, in rising address order, over a ready/valid handshake to the memory side.

Segment data comes back on a response channel. It is steered to every lane whose address falls inside that segment. Each lane receives its own bytes at the low end of its data slot.

A group input picks the transaction size: 32, 64 or 128 bytes. When the whole group is served, the unit raises a one-cycle completion strobe. At that strobe it reports the number of transactions, the number of distinct bytes the lanes asked for, and the number of bytes fetched. The gap between the last two is the waste caused by scattered or sparse access patterns.

Top module: `coal_unit`

## Requirements
- R1: All enabled, error-free lanes whose addresses share one aligned segment are served by exactly one transaction. `txn_count` equals the number of distinct segments in the group.
- R2: `grp_seg_sel` sets the segment size: code 0 gives 32 bytes, code 1 gives 64 bytes, codes 2 and 3 give 128 bytes. `mreq_bytes` shows the size. Every `mreq_addr` is aligned to it, so no transaction is narrower than 32 bytes.
- R3: Transactions of one group leave in strictly ascending address order, at most one per cycle. While `mreq_valid` is high and `mreq_ready` is low, the request and its address stay unchanged.
- R4: After completion, each served lane's slot in `lane_data` holds the bytes at its address. The byte at the lane address is in bits [7:0], and the following bytes sit above it in increasing order. All bytes past the access width are zero.
- R5: At completion, `used_bytes` is the count of distinct byte addresses requested by served lanes. `fetched_bytes` equals `txn_count` times the segment size.
- R6: `grp_lane_size` is coded per lane as 0 = 4 bytes, 1 = 8 bytes and 2 = 16 bytes. Each vector access is one request and never adds a transaction beyond its segment.
- R7: A lane is in error if it is enabled and either uses size code 3 or has an address that is not a multiple of its width. Such a lane raises its `lane_err` bit, causes no fetch, adds nothing to `used_bytes`, and gets all-zero data. Disabled lanes also get zero data and no error.
- R8: `done_valid` pulses for one cycle, and only after every issued segment has come back. A group with no served lane completes with all counts zero.
- R9: `grp_ready` is high only while the unit is idle. A group is accepted on a cycle with `grp_valid` and `grp_ready` both high.
- R10: After reset, `grp_ready` is 1, and `mreq_valid` and `done_valid` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| grp_valid | input | 1 | A request group is offered |
| grp_ready | output | 1 | Unit is idle and takes a group |
| grp_seg_sel | input | 2 | Segment size code |
| grp_lane_en | input | 32 | Per-lane request enable |
| grp_lane_addr | input | 1024 | Per-lane byte address, lane i at [32i+31:32i] |
| grp_lane_size | input | 64 | Per-lane width code, lane i at [2i+1:2i] |
| mreq_valid | output | 1 | Segment fetch request valid |
| mreq_ready | input | 1 | Memory accepts the request |
| mreq_addr | output | 32 | Aligned segment base address |
| mreq_bytes | output | 8 | Segment size in bytes |
| mrsp_valid | input | 1 | Segment data returned |
| mrsp_addr | input | 32 | Base address of the returned segment |
| mrsp_data | input | 1024 | Segment data, byte k at [8k+7:8k] |
| done_valid | output | 1 | One-cycle group completion strobe |
| lane_err | output | 32 | Per-lane error flags |
| lane_data | output | 4096 | Per-lane data, lane i at [128i+127:128i] |
| txn_count | output | 6 | Transactions issued for the group |
| used_bytes | output | 13 | Distinct requested bytes |
| fetched_bytes | output | 13 | Bytes fetched |

## Verification
The assertions make three assumptions about the memory side. It returns each issued segment exactly once. It echoes the segment base address. It never answers in the same cycle as the handshake that issued the request.

The bench keeps to these assumptions with a fixed-latency responder pipeline fed only by accepted handshakes. It stalls `mreq_ready` at random, so the hold rule is exercised under back-pressure. Lane addresses are drawn inside a bounded window below the top of the address space, so segment bases never wrap. Misaligned addresses and size code 3 are injected on purpose to drive the error path.

// File: rtl/coal_pkg.sv
// Shared types and size decoding for the request coalescing unit.
// Assumes segment codes 0/1/2+ mean 32/64/128 bytes and lane codes 0/1/2 mean 4/8/16 bytes.
package coal_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_BUSY = 2'd1,
        ST_DONE = 2'd2
    } coal_state_e;

    // Lane width code to byte count; code 3 is illegal and yields 0.
    function automatic logic [7:0] lane_bytes(input logic [1:0] code);
        case (code)
            2'd0:    return 8'd4;
            2'd1:    return 8'd8;
            2'd2:    return 8'd16;
            default: return 8'd0;
        endcase
    endfunction

    // Segment code to byte count.
    function automatic logic [7:0] seg_bytes(input logic [1:0] code);
        case (code)
            2'd0:    return 8'd32;
            2'd1:    return 8'd64;
            default: return 8'd128;
        endcase
    endfunction

endpackage

// File: rtl/coal_lane_decode.sv
// Per-lane decode of a group: validity, alignment check, segment base and offset.
// Purely combinational; assumes lane widths never exceed the smallest segment.
module coal_lane_decode
    import coal_pkg::*;
#(
    parameter int LANES = 32,
    parameter int AW    = 32,
    parameter int OFFW  = 7,
    parameter int NBW   = 5
) (
    input  logic [LANES-1:0]      en,
    input  logic [LANES*AW-1:0]   addr,
    input  logic [LANES*2-1:0]    size,
    input  logic [1:0]            seg_sel,
    output logic [LANES-1:0]      ok,
    output logic [LANES-1:0]      err,
    output logic [LANES*AW-1:0]   base,
    output logic [LANES*OFFW-1:0] off,
    output logic [LANES*NBW-1:0]  nbytes
);

    logic [7:0] segb;
    assign segb = seg_bytes(seg_sel);

    for (genvar i = 0; i < LANES; i++) begin : g_lane
        logic [AW-1:0] a;
        logic [1:0]    sc;
        logic [7:0]    nb;
        logic          mis;

        assign a   = addr[i*AW +: AW];
        assign sc  = size[i*2 +: 2];
        assign nb  = lane_bytes(sc);
        // Natural alignment: low address bits below the width must be zero.
        assign mis = (a & AW'(nb - 8'd1)) != '0;

        assign ok[i]  = en[i] && (sc != 2'd3) && !mis;
        assign err[i] = en[i] && !ok[i];
        assign base[i*AW +: AW]     = a & ~AW'(segb - 8'd1);
        assign off[i*OFFW +: OFFW]  = OFFW'(a) & OFFW'(segb - 8'd1);
        assign nbytes[i*NBW +: NBW] = NBW'(nb);
    end

endmodule

// File: rtl/coal_seg_pick.sv
// Picks the lowest pending segment base, the lanes it covers and its distinct byte count.
// Combinational; assumes each lane's bytes lie wholly inside its segment.
module coal_seg_pick #(
    parameter int LANES   = 32,
    parameter int AW      = 32,
    parameter int SEG_MAX = 128,
    parameter int OFFW    = 7,
    parameter int NBW     = 5,
    parameter int UCW     = 8
) (
    input  logic [LANES-1:0]      pending,
    input  logic [LANES*AW-1:0]   base,
    input  logic [LANES*OFFW-1:0] off,
    input  logic [LANES*NBW-1:0]  nbytes,
    output logic                  any,
    output logic [AW-1:0]         pick_addr,
    output logic [LANES-1:0]      match,
    output logic [UCW-1:0]        used
);

    logic [SEG_MAX-1:0] bmask;

    // Minimum search over pending lanes.
    always_comb begin
        any       = 1'b0;
        pick_addr = '0;
        for (int i = 0; i < LANES; i++) begin
            if (pending[i] && (!any || base[i*AW +: AW] < pick_addr)) begin
                pick_addr = base[i*AW +: AW];
                any       = 1'b1;
            end
        end
    end

    // Lanes sharing the chosen segment, and the union of their bytes.
    always_comb begin
        bmask = '0;
        for (int i = 0; i < LANES; i++) begin
            match[i] = pending[i] && (base[i*AW +: AW] == pick_addr);
            if (match[i]) begin
                bmask = bmask | ((((SEG_MAX)'(1)) << nbytes[i*NBW +: NBW]) - (SEG_MAX)'(1))
                                 << off[i*OFFW +: OFFW];
            end
        end
        used = UCW'($countones(bmask));
    end

endmodule

// File: rtl/coal_lane_route.sv
// Steers a returned segment to every served lane inside it, low-aligned and width-masked.
// Combinational; assumes the response address is a segment base the unit issued.
module coal_lane_route #(
    parameter int LANES   = 32,
    parameter int AW      = 32,
    parameter int SEG_MAX = 128,
    parameter int LW      = 128,
    parameter int OFFW    = 7,
    parameter int NBW     = 5
) (
    input  logic                  rsp_valid,
    input  logic [AW-1:0]         rsp_addr,
    input  logic [SEG_MAX*8-1:0]  rsp_data,
    input  logic [LANES-1:0]      ok,
    input  logic [LANES*AW-1:0]   base,
    input  logic [LANES*OFFW-1:0] off,
    input  logic [LANES*NBW-1:0]  nbytes,
    output logic [LANES-1:0]      hit,
    output logic [LANES*LW-1:0]   data
);

    for (genvar i = 0; i < LANES; i++) begin : g_route
        logic [LW-1:0]   slice;
        logic [LW-1:0]   keep;

        assign hit[i] = rsp_valid && ok[i] && (base[i*AW +: AW] == rsp_addr);
        assign slice  = LW'(rsp_data >> {off[i*OFFW +: OFFW], 3'b000});
        assign keep   = ((LW)'(1) << {nbytes[i*NBW +: NBW], 3'b000}) - (LW)'(1);
        assign data[i*LW +: LW] = slice & keep;
    end

endmodule

// File: rtl/coal_unit.sv
// Request coalescing unit: accepts a lane group, issues one fetch per distinct aligned
// segment in ascending order, routes returned data to lanes and reports byte statistics.
// Assumes memory returns each issued segment once, at least one cycle after issue.
module coal_unit
    import coal_pkg::*;
#(
    parameter int LANES    = 32,
    parameter int AW       = 32,
    parameter int SEG_MAX  = 128,
    parameter int LANE_MAX = 16
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    grp_valid,
    output logic                    grp_ready,
    input  logic [1:0]              grp_seg_sel,
    input  logic [LANES-1:0]        grp_lane_en,
    input  logic [LANES*AW-1:0]     grp_lane_addr,
    input  logic [LANES*2-1:0]      grp_lane_size,
    output logic                    mreq_valid,
    input  logic                    mreq_ready,
    output logic [AW-1:0]           mreq_addr,
    output logic [7:0]              mreq_bytes,
    input  logic                    mrsp_valid,
    input  logic [AW-1:0]           mrsp_addr,
    input  logic [SEG_MAX*8-1:0]    mrsp_data,
    output logic                    done_valid,
    output logic [LANES-1:0]        lane_err,
    output logic [LANES*LANE_MAX*8-1:0] lane_data,
    output logic [$clog2(LANES+1)-1:0]         txn_count,
    output logic [$clog2(LANES*SEG_MAX+1)-1:0] used_bytes,
    output logic [$clog2(LANES*SEG_MAX+1)-1:0] fetched_bytes
);

    localparam int LW   = LANE_MAX * 8;
    localparam int OFFW = $clog2(SEG_MAX);
    localparam int NBW  = $clog2(LANE_MAX) + 1;
    localparam int UCW  = $clog2(SEG_MAX + 1);
    localparam int TW   = $clog2(LANES + 1);
    localparam int CNTW = $clog2(LANES * SEG_MAX + 1);

    coal_state_e           state;
    logic [1:0]            seg_q;
    logic [LANES-1:0]      ok_q;
    logic [LANES*AW-1:0]   base_q;
    logic [LANES*OFFW-1:0] off_q;
    logic [LANES*NBW-1:0]  nb_q;
    logic [LANES-1:0]      pending;
    logic [TW-1:0]         outstanding;
    logic [AW-1:0]         last_addr;
    logic                  have_prev;

    logic [LANES-1:0]      d_ok, d_err;
    logic [LANES*AW-1:0]   d_base;
    logic [LANES*OFFW-1:0] d_off;
    logic [LANES*NBW-1:0]  d_nb;

    logic                  pick_any;
    logic [AW-1:0]         pick_addr;
    logic [LANES-1:0]      pick_match;
    logic [UCW-1:0]        pick_used;

    logic [LANES-1:0]      r_hit;
    logic [LANES*LW-1:0]   r_data;

    logic                  accept, fire, rsp_take;

    coal_lane_decode #(.LANES(LANES), .AW(AW), .OFFW(OFFW), .NBW(NBW)) i_decode (
        .en(grp_lane_en), .addr(grp_lane_addr), .size(grp_lane_size), .seg_sel(grp_seg_sel),
        .ok(d_ok), .err(d_err), .base(d_base), .off(d_off), .nbytes(d_nb)
    );

    coal_seg_pick #(.LANES(LANES), .AW(AW), .SEG_MAX(SEG_MAX), .OFFW(OFFW), .NBW(NBW),
                    .UCW(UCW)) i_pick (
        .pending(pending), .base(base_q), .off(off_q), .nbytes(nb_q),
        .any(pick_any), .pick_addr(pick_addr), .match(pick_match), .used(pick_used)
    );

    coal_lane_route #(.LANES(LANES), .AW(AW), .SEG_MAX(SEG_MAX), .LW(LW), .OFFW(OFFW),
                      .NBW(NBW)) i_route (
        .rsp_valid(rsp_take), .rsp_addr(mrsp_addr), .rsp_data(mrsp_data), .ok(ok_q),
        .base(base_q), .off(off_q), .nbytes(nb_q), .hit(r_hit), .data(r_data)
    );

    assign grp_ready  = (state == ST_IDLE);
    assign accept     = grp_valid && grp_ready;
    assign mreq_valid = (state == ST_BUSY) && pick_any;
    assign mreq_addr  = pick_addr;
    assign mreq_bytes = seg_bytes(seg_q);
    assign fire       = mreq_valid && mreq_ready;
    assign rsp_take   = (state == ST_BUSY) && mrsp_valid;
    assign done_valid = (state == ST_DONE);

    // Group state machine, issue bookkeeping and statistics.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state         <= ST_IDLE;
            seg_q         <= '0;
            ok_q          <= '0;
            lane_err      <= '0;
            base_q        <= '0;
            off_q         <= '0;
            nb_q          <= '0;
            pending       <= '0;
            outstanding   <= '0;
            last_addr     <= '0;
            have_prev     <= 1'b0;
            txn_count     <= '0;
            used_bytes    <= '0;
            fetched_bytes <= '0;
        end else begin
            case (state)
                ST_IDLE: begin
                    if (accept) begin
                        seg_q         <= grp_seg_sel;
                        ok_q          <= d_ok;
                        lane_err      <= d_err;
                        base_q        <= d_base;
                        off_q         <= d_off;
                        nb_q          <= d_nb;
                        pending       <= d_ok;
                        outstanding   <= '0;
                        have_prev     <= 1'b0;
                        txn_count     <= '0;
                        used_bytes    <= '0;
                        fetched_bytes <= '0;
                        state         <= ST_BUSY;
                    end
                end
                ST_BUSY: begin
                    if (fire) begin
                        pending       <= pending & ~pick_match;
                        txn_count     <= txn_count + TW'(1);
                        used_bytes    <= used_bytes + CNTW'(pick_used);
                        fetched_bytes <= fetched_bytes + CNTW'(mreq_bytes);
                        last_addr     <= pick_addr;
                        have_prev     <= 1'b1;
                    end
                    outstanding <= outstanding + TW'(fire) - TW'(rsp_take);
                    if (!pick_any && outstanding == '0) begin
                        state <= ST_DONE;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // Per-lane data capture: cleared on acceptance, written when the lane's segment returns.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lane_data <= '0;
        end else if (accept) begin
            lane_data <= '0;
        end else begin
            for (int i = 0; i < LANES; i++) begin
                if (r_hit[i]) lane_data[i*LW +: LW] <= r_data[i*LW +: LW];
            end
        end
    end

    // R3: a stalled request keeps its address.
    p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        mreq_valid && !mreq_ready |=> mreq_valid && $stable(mreq_addr));

    // R3: issued segments strictly increase within a group.
    p_order_r3: assert property (@(posedge clk) disable iff (!rst_n)
        fire && have_prev |-> mreq_addr > last_addr);

    // R2: every request is aligned to the selected segment size.
    p_align_r2: assert property (@(posedge clk) disable iff (!rst_n)
        mreq_valid |-> (mreq_addr & AW'(mreq_bytes - 8'd1)) == '0);

    // R1: an issued segment serves at least one lane.
    p_cover_r1: assert property (@(posedge clk) disable iff (!rst_n)
        mreq_valid |-> pick_match != '0);

    // R7: error lanes are never part of a fetch.
    p_noerr_r7: assert property (@(posedge clk) disable iff (!rst_n)
        fire |-> (pick_match & lane_err) == '0);

    // R8: responses only for outstanding segments; completion only when nothing is in flight.
    p_rsp_known_r8: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_take |-> outstanding != '0);
    p_done_r8: assert property (@(posedge clk) disable iff (!rst_n)
        done_valid |-> outstanding == '0 && !mreq_valid);
    p_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
        done_valid |=> !done_valid);

    // R5: used bytes never exceed fetched bytes at completion.
    p_stats_r5: assert property (@(posedge clk) disable iff (!rst_n)
        done_valid |-> used_bytes <= fetched_bytes);

    // R9: a taken group makes the unit busy.
    p_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> !grp_ready);

endmodule

// File: tb/test_coal_unit.sv
// Self-checking bench: directed corner groups plus seeded random groups against a
// fixed-latency ideal memory and a reference model built from the requirements.
module test_coal_unit;

    localparam int LANES = 32;
    localparam int AW    = 32;
    localparam int SEGB  = 128;
    localparam int LAT   = 3;

    logic                  clk = 1'b0;
    logic                  rst_n = 1'b0;
    logic                  grp_valid = 1'b0;
    logic                  grp_ready;
    logic [1:0]            grp_seg_sel = '0;
    logic [LANES-1:0]      grp_lane_en = '0;
    logic [LANES*AW-1:0]   grp_lane_addr = '0;
    logic [LANES*2-1:0]    grp_lane_size = '0;
    logic                  mreq_valid;
    logic                  mreq_ready = 1'b0;
    logic [AW-1:0]         mreq_addr;
    logic [7:0]            mreq_bytes;
    logic                  mrsp_valid;
    logic [AW-1:0]         mrsp_addr;
    logic [SEGB*8-1:0]     mrsp_data;
    logic                  done_valid;
    logic [LANES-1:0]      lane_err;
    logic [LANES*128-1:0]  lane_data;
    logic [5:0]            txn_count;
    logic [12:0]           used_bytes;
    logic [12:0]           fetched_bytes;

    int errors = 0;
    int checks = 0;
    int cycles = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;

    coal_unit i_coal_unit (
        .clk(clk), .rst_n(rst_n), .grp_valid(grp_valid), .grp_ready(grp_ready),
        .grp_seg_sel(grp_seg_sel), .grp_lane_en(grp_lane_en), .grp_lane_addr(grp_lane_addr),
        .grp_lane_size(grp_lane_size), .mreq_valid(mreq_valid), .mreq_ready(mreq_ready),
        .mreq_addr(mreq_addr), .mreq_bytes(mreq_bytes), .mrsp_valid(mrsp_valid),
        .mrsp_addr(mrsp_addr), .mrsp_data(mrsp_data), .done_valid(done_valid),
        .lane_err(lane_err), .lane_data(lane_data), .txn_count(txn_count),
        .used_bytes(used_bytes), .fetched_bytes(fetched_bytes)
    );

    // Memory content as a function of the byte address.
    function automatic logic [7:0] mbyte(input logic [31:0] a);
        return a[7:0] ^ a[15:8] ^ 8'h5A;
    endfunction

    // Ideal fixed-latency memory.
    logic            pv [LAT];
    logic [AW-1:0]   pa [LAT];
    initial for (int k = 0; k < LAT; k++) begin pv[k] = 1'b0; pa[k] = '0; end
    always @(posedge clk) begin
        pv[0] <= mreq_valid && mreq_ready && rst_n;
        pa[0] <= mreq_addr;
        for (int k = 1; k < LAT; k++) begin
            pv[k] <= pv[k-1];
            pa[k] <= pa[k-1];
        end
    end
    assign mrsp_valid = pv[LAT-1];
    assign mrsp_addr  = pa[LAT-1];
    always_comb begin
        for (int b = 0; b < SEGB; b++) mrsp_data[b*8 +: 8] = mbyte(pa[LAT-1] + 32'(b));
    end

    // Random back-pressure.
    always @(negedge clk) mreq_ready <= ($urandom % 4) != 0;

    // Monitor of issued and returned segments.
    logic [AW-1:0] iss [64];
    int n_iss = 0;
    int n_rsp = 0;
    always @(posedge clk) begin
        if (mreq_valid && mreq_ready) begin
            if (n_iss < 64) iss[n_iss] = mreq_addr;
            n_iss = n_iss + 1;
        end
        if (mrsp_valid) n_rsp = n_rsp + 1;
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [127:0] act, input logic [127:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1'b1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    endtask

    // Watchdog.
    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=%0d expected=<150000", cycles);
            summary();
        end
    end

    // Stimulus description of the next group.
    bit            t_en   [LANES];
    logic [31:0]   t_addr [LANES];
    logic [1:0]    t_sz   [LANES];

    function automatic int wbytes(input logic [1:0] c);
        return (c == 2'd0) ? 4 : (c == 2'd1) ? 8 : (c == 2'd2) ? 16 : 0;
    endfunction

    function automatic int sbytes(input logic [1:0] c);
        return (c == 2'd0) ? 32 : (c == 2'd1) ? 64 : 128;
    endfunction

    task automatic clear_lanes();
        for (int i = 0; i < LANES; i++) begin
            t_en[i] = 1'b0; t_addr[i] = '0; t_sz[i] = 2'd0;
        end
    endtask

    task automatic run_group(input logic [1:0] sel, input string tag);
        bit            okl  [LANES];
        logic [31:0]   segs [64];
        int            nseg = 0;
        int            sb   = sbytes(sel);
        int            used = 0;
        int            to   = 0;
        // Reference model: lane validity, distinct segments, distinct bytes.
        for (int i = 0; i < LANES; i++) begin
            int w = wbytes(t_sz[i]);
            okl[i] = t_en[i] && (w != 0) && ((t_addr[i] % w) == 0);
        end
        for (int i = 0; i < LANES; i++) begin
            if (okl[i]) begin
                logic [31:0] b = t_addr[i] & ~(32'(sb) - 32'd1);
                bit seen = 1'b0;
                for (int k = 0; k < nseg; k++) if (segs[k] == b) seen = 1'b1;
                if (!seen) begin segs[nseg] = b; nseg++; end
                for (int j = 0; j < wbytes(t_sz[i]); j++) begin
                    logic [31:0] a = t_addr[i] + 32'(j);
                    bit dup = 1'b0;
                    for (int k = 0; k < i; k++)
                        if (okl[k] && a >= t_addr[k] && a < t_addr[k] + 32'(wbytes(t_sz[k])))
                            dup = 1'b1;
                    if (!dup) used++;
                end
            end
        end
        for (int x = 1; x < nseg; x++)
            for (int y = x; y > 0 && segs[y-1] > segs[y]; y--) begin
                logic [31:0] t = segs[y]; segs[y] = segs[y-1]; segs[y-1] = t;
            end
        // Drive the group.
        @(negedge clk);
        n_iss = 0;
        n_rsp = 0;
        grp_seg_sel = sel;
        for (int i = 0; i < LANES; i++) begin
            grp_lane_en[i]              = t_en[i];
            grp_lane_addr[i*AW +: AW]   = t_addr[i];
            grp_lane_size[i*2 +: 2]     = t_sz[i];
        end
        grp_valid = 1'b1;
        chk(grp_ready == 1'b1, "R9", {tag, " ready when idle"}, 128'(grp_ready), 128'd1);
        @(negedge clk);
        grp_valid = 1'b0;
        chk(grp_ready == 1'b0, "R9", {tag, " busy after accept"}, 128'(grp_ready), 128'd0);
        while (!done_valid && to < 3000) begin @(negedge clk); to++; end
        chk(done_valid == 1'b1, "R8", {tag, " completion"}, 128'(done_valid), 128'd1);
        chk(n_rsp == n_iss, "R8", {tag, " all segments returned"}, 128'(n_rsp), 128'(n_iss));
        chk(txn_count == 6'(nseg) && n_iss == nseg, "R1", {tag, " transaction count"},
            128'(n_iss), 128'(nseg));
        for (int k = 0; k < nseg && k < n_iss; k++)
            chk(iss[k] == segs[k], "R3", {tag, " segment order"}, 128'(iss[k]), 128'(segs[k]));
        chk(used_bytes == 13'(used), "R5", {tag, " used bytes"}, 128'(used_bytes), 128'(used));
        chk(fetched_bytes == 13'(nseg * sb), "R5", {tag, " fetched bytes"},
            128'(fetched_bytes), 128'(nseg * sb));
        for (int i = 0; i < LANES; i++) begin
            logic [127:0] e = '0;
            bit ee = t_en[i] && !okl[i];
            if (okl[i]) for (int j = 0; j < wbytes(t_sz[i]); j++)
                e[j*8 +: 8] = mbyte(t_addr[i] + 32'(j));
            chk(lane_err[i] == ee, "R7", {tag, " lane error flag"}, 128'(lane_err[i]), 128'(ee));
            chk(lane_data[i*128 +: 128] == e, "R4", {tag, " lane data"},
                lane_data[i*128 +: 128], e);
        end
        @(negedge clk);
        chk(done_valid == 1'b0, "R8", {tag, " single-cycle done"}, 128'(done_valid), 128'd0);
    endtask

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(grp_ready == 1'b1, "R10", "reset ready", 128'(grp_ready), 128'd1);
        chk(mreq_valid == 1'b0, "R10", "reset request", 128'(mreq_valid), 128'd0);
        chk(done_valid == 1'b0, "R10", "reset done", 128'(done_valid), 128'd0);

        // R1/R5: ten 4-byte words in one 64-byte block -> one fetch, 40 used, 64 fetched.
        clear_lanes();
        for (int i = 0; i < 10; i++) begin t_en[i] = 1'b1; t_addr[i] = 32'h0000_1040 + 32'(i*4); end
        run_group(2'd1, "ten-words");

        // R2: a lone request still fetches 32 bytes.
        clear_lanes();
        t_en[5] = 1'b1; t_addr[5] = 32'h0000_2008; t_sz[5] = 2'd1;
        run_group(2'd0, "lone-32");

        // R5: twelve 4-byte lanes cannot fill a 64-byte segment.
        clear_lanes();
        for (int i = 0; i < 12; i++) begin t_en[i] = 1'b1; t_addr[i] = 32'h0000_3000 + 32'(i*4); end
        run_group(2'd1, "under-use");

        // R6: eight 16-byte vector lanes fill one 128-byte segment.
        clear_lanes();
        for (int i = 0; i < 8; i++) begin
            t_en[i*4] = 1'b1; t_addr[i*4] = 32'h0000_4000 + 32'(i*16); t_sz[i*4] = 2'd2;
        end
        run_group(2'd2, "vec16");

        // R6/R2: 8-byte lanes, reversed addresses, 32-byte segments, code 3 = 128.
        clear_lanes();
        for (int i = 0; i < 32; i++) begin
            t_en[i] = 1'b1; t_addr[i] = 32'h0000_5000 + 32'((31 - i) * 8); t_sz[i] = 2'd1;
        end
        run_group(2'd0, "vec8-rev32");
        run_group(2'd3, "vec8-rev128");

        // R7: misaligned lane, illegal size, and a duplicate address.
        clear_lanes();
        t_en[0] = 1'b1; t_addr[0] = 32'h0000_6004; t_sz[0] = 2'd1;
        t_en[1] = 1'b1; t_addr[1] = 32'h0000_6010; t_sz[1] = 2'd3;
        t_en[2] = 1'b1; t_addr[2] = 32'h0000_6020; t_sz[2] = 2'd0;
        t_en[3] = 1'b1; t_addr[3] = 32'h0000_6020; t_sz[3] = 2'd0;
        t_en[4] = 1'b1; t_addr[4] = 32'h0000_6026; t_sz[4] = 2'd0;
        run_group(2'd1, "errors");

        // R8: empty group.
        clear_lanes();
        run_group(2'd1, "empty");

        // Random groups.
        for (int g = 0; g < 40; g++) begin
            int mode = $urandom % 3;
            logic [31:0] base = ($urandom & 32'h7FFF_F000);
            clear_lanes();
            for (int i = 0; i < LANES; i++) begin
                int w;
                t_en[i] = ($urandom % 4) != 0;
                t_sz[i] = ($urandom % 20 == 0) ? 2'd3 : 2'($urandom % 3);
                w = (t_sz[i] == 2'd3) ? 4 : wbytes(t_sz[i]);
                if (mode == 0)
                    t_addr[i] = base + 32'((($urandom % 1024) / w) * w);
                else
                    t_addr[i] = base + 32'(i * w * (mode == 1 ? 1 : 4));
                if ($urandom % 25 == 0) t_addr[i] = t_addr[i] + 32'd2;
            end
            run_group(2'($urandom % 4), "random");
        end
        summary();
    end

endmodule